// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block holds a small, fully associative set of segment entries for a 64-bit address translation path. Each entry pairs an effective segment word (segment number plus a valid bit) with a 64-bit virtual segment word. The virtual segment word carries a segment size, protection keys, a no-execute flag, a class bit and a page-size code. A translation unit presents the upper effective-address bits on a dedicated lookup port and receives the hit slot and the stored virtual segment word. Segments of 256MB and of 1TB are matched in the same pass, and the lowest-numbered matching slot wins.

A second, command port serves maintenance operations. These are an indexed write with legality checks, indexed reads of either word, an associative search that returns the virtual segment word, single-entry invalidate in local and global flavours, and invalidate-all with a 3-bit mode field. Each invalidate raises a one-cycle flush request toward the downstream translation cache. The set of legal page-size codes is a parameter list, so the block needs no encoding table of its own.

Top module: `slb_array`

## Requirements
- R1: Reset clears every valid bit and both flush outputs. After reset, a lookup misses and an indexed read of the effective word of any slot returns 0.
- R2: An entry hits when it is valid and one of two conditions holds. In the first, its size field (virtual word bits 63:62) is 00 and its stored segment number equals effective address bits 63:28. In the second, the size field is 01, stored segment bits 35:12 equal address bits 63:40, and stored segment bits 11:0 are zero. When several entries hit, the lowest slot wins.
- R3: Command op 0 is a write. The slot comes from cmd_addr[11:0], the segment number from cmd_addr[63:28], the valid bit from cmd_addr[27], and the virtual word from cmd_data. The write is rejected when the slot is not below NUM_ENT or when any of cmd_addr[26:12] is set. A rejected write pulses rsp_err and leaves the entry unchanged.
- R4: A write is rejected when cmd_data[63] is set, or when cmd_data[62] is set while cfg_1t_en is low.
- R5: A write is rejected when the page-size code {cmd_data[8], cmd_data[5:4]} is not in the PS_LIST parameter. The default list holds 000, 100 and 101.
- R6: Op 1 returns the effective word {segment, valid, 27 zero bits} of slot cmd_addr[11:0], and op 2 returns the virtual word of that slot. A slot not below NUM_ENT gives rsp_err.
- R7: Op 3 searches for cmd_addr and returns the winning entry's virtual word, or all ones on a miss. When cfg_mode32 is high, address bits 63:32 are treated as zero for the search.
- R8: Op 4 (local) and op 5 (global) look up cmd_addr. On a hit they clear the valid bit of the winning entry only, and raise flush_local or flush_global respectively. On a miss they change nothing and raise no flush.
- R9: Op 6 clears valid on every entry except slot 0 for modes 0, 1, 2, 5 and 6. When cfg_new_model is low it does so for every mode. It always raises flush_local, even when nothing was valid.
- R10: With cfg_new_model high, mode 4 clears every entry including slot 0. Mode 3 also includes slot 0, but keeps entries whose class bit (virtual word bit 7) is 0.
- R11: With cfg_new_model high, mode 7 clears no entry but still raises flush_local.
- R12: With LK_REG=1, lk_rsp_valid, lk_hit, lk_slot and lk_vsid present the result for lk_seg exactly one cycle after lk_req. lk_vsid is 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_new_model | input | 1 | Enables the extended invalidate-all modes |
| cfg_1t_en | input | 1 | Permits writes of 1TB segments |
| cfg_mode32 | input | 1 | Search treats address bits 63:32 as zero |
| lk_req | input | 1 | Lookup request |
| lk_seg | input | 36 | Effective address bits 63:28 to look up |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_slot | output | 5 | Winning slot |
| lk_vsid | output | 64 | Virtual word of the winning slot, 0 on miss |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..6, 7 is no operation) |
| cmd_addr | input | 64 | Address or slot operand |
| cmd_data | input | 64 | Virtual word for writes |
| cmd_mode | input | 3 | Invalidate-all mode |
| rsp_valid | output | 1 | Command completed |
| rsp_data | output | 64 | Read or search result |
| rsp_err | output | 1 | Rejected write or out-of-range read |
| flush_local | output | 1 | One-cycle local flush request |
| flush_global | output | 1 | One-cycle global flush request |

## Verification
Every command result is registered. rsp_valid, rsp_data, rsp_err and both flush pulses are due on the first rising edge after the edge that accepts the command. The entry changes a command makes are visible to any command or lookup accepted on the next edge. The registered lookup result is due one edge after lk_req. The bench drives on the falling edge, holds the strobe for exactly one rising edge, and samples on the next falling edge. Each sample therefore lands in the single cycle the pulse or result occupies.

// File: rtl/slb_pkg.sv
package slb_pkg;
   localparam int WORD_W       = 64;
   localparam int SEG256_LSB   = 28;
   localparam int SEG1T_LSB    = 40;
   localparam int ESID_W       = WORD_W - SEG256_LSB;
   localparam int VALID_BIT    = 27;
   localparam int SLOT_FIELD_W = 12;
   localparam int RSVD_W       = VALID_BIT - SLOT_FIELD_W;
   localparam int SIZE_LSB     = 62;
   localparam int CLASS_BIT    = 7;
   localparam int LARGE_BIT    = 8;
   localparam int LP_LSB       = 4;
   localparam int MODE32_W     = 32 - SEG256_LSB;

   typedef enum logic [2:0] {
      OP_WRITE     = 3'd0,
      OP_RD_ESID   = 3'd1,
      OP_RD_VSID   = 3'd2,
      OP_SEARCH    = 3'd3,
      OP_INV_ONE   = 3'd4,
      OP_INV_ONE_G = 3'd5,
      OP_INV_ALL   = 3'd6,
      OP_NONE      = 3'd7
   } slb_op_e;

   localparam logic [1:0] SZ_256M = 2'b00;
   localparam logic [1:0] SZ_1T   = 2'b01;

   function automatic logic [2:0] page_code(input logic [WORD_W-1:0] v);
      return {v[LARGE_BIT], v[LP_LSB+1:LP_LSB]};
   endfunction
endpackage

// File: rtl/slb_match.sv
module slb_match
   import slb_pkg::*;
#(
   parameter int NUM_ENT = 32,
   parameter int SLOT_W  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ENT-1:0]  ent_valid,
   input  logic [ESID_W-1:0]   ent_esid [NUM_ENT],
   input  logic [1:0]          ent_size [NUM_ENT],
   input  logic [ESID_W-1:0]   key_seg,
   output logic                hit,
   output logic [SLOT_W-1:0]   idx
);
   localparam int LO1T = SEG1T_LSB - SEG256_LSB;

   logic [NUM_ENT-1:0] raw;
   logic [NUM_ENT-1:0] first;

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
      logic m256, m1t;
      assign m256 = (ent_size[i] == SZ_256M) && (ent_esid[i] == key_seg);
      assign m1t  = (ent_size[i] == SZ_1T)
                 && (ent_esid[i][ESID_W-1:LO1T] == key_seg[ESID_W-1:LO1T])
                 && (ent_esid[i][LO1T-1:0] == '0);
      assign raw[i] = ent_valid[i] && (m256 || m1t);
   end

   always_comb begin
      logic seen;
      seen  = 1'b0;
      first = '0;
      idx   = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         if (raw[i] && !seen) begin
            first[i] = 1'b1;
            idx      = SLOT_W'(i);
         end
         seen = seen | raw[i];
      end
   end

   assign hit = |raw;

   // R2: at most one winner, and the winner is a valid entry
   a_r2_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(first));
   a_r2_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ent_valid[idx]);
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
   import slb_pkg::*;
#(
   parameter int               NUM_ENT = 32,
   parameter int               NUM_PS  = 3,
   parameter logic [3*NUM_PS-1:0] PS_LIST = {3'b101, 3'b100, 3'b000}
) (
   input  logic [SLOT_FIELD_W-1:0] slot,
   input  logic [RSVD_W-1:0]       rsvd,
   input  logic [1:0]              size,
   input  logic [2:0]              code,
   input  logic                    en_1t,
   output logic                    slot_ok,
   output logic                    wr_ok
);
   logic [NUM_PS-1:0] code_hit;
   logic              size_ok;

   for (genvar p = 0; p < NUM_PS; p++) begin : g_ps
      assign code_hit[p] = (code == PS_LIST[3*p +: 3]);
   end

   assign slot_ok = (int'(slot) < NUM_ENT);
   assign size_ok = !size[1] && !(size[0] && !en_1t);
   assign wr_ok   = slot_ok && (rsvd == '0) && size_ok && (|code_hit);
endmodule

// File: rtl/slb_inv_sel.sv
module slb_inv_sel #(
   parameter int NUM_ENT = 32
) (
   input  logic [NUM_ENT-1:0] ent_class,
   input  logic [2:0]         mode,
   input  logic               new_model,
   output logic [NUM_ENT-1:0] clr
);
   logic with_zero, keep_c0, none;

   assign with_zero = new_model && ((mode == 3'd3) || (mode == 3'd4));
   assign keep_c0   = new_model && (mode == 3'd3);
   assign none      = new_model && (mode == 3'd7);

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_sel
      if (i == 0) begin : g_zero
         assign clr[i] = !none && with_zero && !(keep_c0 && !ent_class[i]);
      end else begin : g_rest
         assign clr[i] = !none && !(keep_c0 && !ent_class[i]);
      end
   end
endmodule

// File: rtl/slb_array.sv
module slb_array
   import slb_pkg::*;
#(
   parameter int               NUM_ENT = 32,
   parameter int               NUM_PS  = 3,
   parameter logic [3*NUM_PS-1:0] PS_LIST = {3'b101, 3'b100, 3'b000},
   parameter bit               LK_REG  = 1'b1,
   localparam int              SLOT_W  = $clog2(NUM_ENT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_new_model,
   input  logic               cfg_1t_en,
   input  logic               cfg_mode32,
   input  logic               lk_req,
   input  logic [ESID_W-1:0]  lk_seg,
   output logic               lk_rsp_valid,
   output logic               lk_hit,
   output logic [SLOT_W-1:0]  lk_slot,
   output logic [WORD_W-1:0]  lk_vsid,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [WORD_W-1:0]  cmd_addr,
   input  logic [WORD_W-1:0]  cmd_data,
   input  logic [2:0]         cmd_mode,
   output logic               rsp_valid,
   output logic [WORD_W-1:0]  rsp_data,
   output logic               rsp_err,
   output logic               flush_local,
   output logic               flush_global
);
   if (NUM_ENT < 2 || NUM_ENT > (1 << SLOT_FIELD_W)) begin : g_bad_ent
      $error("slb_array: NUM_ENT out of range");
   end
   if (NUM_PS < 1) begin : g_bad_ps
      $error("slb_array: PS_LIST must hold at least one code");
   end

   logic [NUM_ENT-1:0] valid_q;
   logic [ESID_W-1:0]  ent_esid [NUM_ENT];
   logic [WORD_W-1:0]  ent_vsid [NUM_ENT];
   logic [1:0]         ent_size [NUM_ENT];
   logic [NUM_ENT-1:0] ent_class;

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_fields
      assign ent_size[i]  = ent_vsid[i][SIZE_LSB+1:SIZE_LSB];
      assign ent_class[i] = ent_vsid[i][CLASS_BIT];
   end

   // command-side match (search and single invalidate)
   logic [ESID_W-1:0] cmd_seg;
   logic              cm_hit;
   logic [SLOT_W-1:0] cm_idx;

   assign cmd_seg = (cmd_op == OP_SEARCH && cfg_mode32)
                  ? {{(ESID_W-MODE32_W){1'b0}}, cmd_addr[31:SEG256_LSB]}
                  : cmd_addr[WORD_W-1:SEG256_LSB];

   slb_match #(.NUM_ENT(NUM_ENT), .SLOT_W(SLOT_W)) u_cmd_match (
      .clk(clk), .rst_n(rst_n), .ent_valid(valid_q), .ent_esid(ent_esid),
      .ent_size(ent_size), .key_seg(cmd_seg), .hit(cm_hit), .idx(cm_idx));

   // lookup-side match
   logic              lm_hit;
   logic [SLOT_W-1:0] lm_idx;

   slb_match #(.NUM_ENT(NUM_ENT), .SLOT_W(SLOT_W)) u_lk_match (
      .clk(clk), .rst_n(rst_n), .ent_valid(valid_q), .ent_esid(ent_esid),
      .ent_size(ent_size), .key_seg(lk_seg), .hit(lm_hit), .idx(lm_idx));

   // write legality and slot range
   logic slot_ok, wr_ok;

   slb_wr_check #(.NUM_ENT(NUM_ENT), .NUM_PS(NUM_PS), .PS_LIST(PS_LIST)) u_chk (
      .slot(cmd_addr[SLOT_FIELD_W-1:0]),
      .rsvd(cmd_addr[VALID_BIT-1:SLOT_FIELD_W]),
      .size(cmd_data[SIZE_LSB+1:SIZE_LSB]),
      .code(page_code(cmd_data)),
      .en_1t(cfg_1t_en),
      .slot_ok(slot_ok),
      .wr_ok(wr_ok));

   // invalidate-all selection
   logic [NUM_ENT-1:0] inv_clr;

   slb_inv_sel #(.NUM_ENT(NUM_ENT)) u_inv (
      .ent_class(ent_class), .mode(cmd_mode), .new_model(cfg_new_model),
      .clr(inv_clr));

   logic [SLOT_W-1:0] slot_idx;
   assign slot_idx = cmd_addr[SLOT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q      <= '0;
         rsp_valid    <= 1'b0;
         rsp_data     <= '0;
         rsp_err      <= 1'b0;
         flush_local  <= 1'b0;
         flush_global <= 1'b0;
         for (int i = 0; i < NUM_ENT; i++) begin
            ent_esid[i] <= '0;
            ent_vsid[i] <= '0;
         end
      end else begin
         rsp_valid    <= 1'b0;
         rsp_err      <= 1'b0;
         flush_local  <= 1'b0;
         flush_global <= 1'b0;
         if (cmd_valid) begin
            rsp_valid <= (cmd_op != OP_NONE);
            case (cmd_op)
               OP_WRITE: begin
                  if (wr_ok) begin
                     ent_esid[slot_idx] <= cmd_addr[WORD_W-1:SEG256_LSB];
                     ent_vsid[slot_idx] <= cmd_data;
                     valid_q[slot_idx]  <= cmd_addr[VALID_BIT];
                  end else begin
                     rsp_err <= 1'b1;
                  end
               end
               OP_RD_ESID: begin
                  if (slot_ok)
                     rsp_data <= {ent_esid[slot_idx], valid_q[slot_idx],
                                  {VALID_BIT{1'b0}}};
                  else
                     rsp_err <= 1'b1;
               end
               OP_RD_VSID: begin
                  if (slot_ok) rsp_data <= ent_vsid[slot_idx];
                  else         rsp_err  <= 1'b1;
               end
               OP_SEARCH: begin
                  rsp_data <= cm_hit ? ent_vsid[cm_idx] : '1;
               end
               OP_INV_ONE, OP_INV_ONE_G: begin
                  if (cm_hit) begin
                     valid_q[cm_idx] <= 1'b0;
                     flush_local     <= (cmd_op == OP_INV_ONE);
                     flush_global    <= (cmd_op == OP_INV_ONE_G);
                  end
               end
               OP_INV_ALL: begin
                  valid_q     <= valid_q & ~inv_clr;
                  flush_local <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // lookup port variant
   if (LK_REG) begin : g_lk_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lk_rsp_valid <= 1'b0;
            lk_hit       <= 1'b0;
            lk_slot      <= '0;
            lk_vsid      <= '0;
         end else begin
            lk_rsp_valid <= lk_req;
            if (lk_req) begin
               lk_hit  <= lm_hit;
               lk_slot <= lm_idx;
               lk_vsid <= lm_hit ? ent_vsid[lm_idx] : '0;
            end
         end
      end

      // R12: result follows the request by exactly one cycle
      a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(lk_req) |-> lk_rsp_valid);
      a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         lk_rsp_valid |-> $past(lk_req));
   end else begin : g_lk_comb
      assign lk_rsp_valid = lk_req;
      assign lk_hit       = lm_hit;
      assign lk_slot      = lm_idx;
      assign lk_vsid      = lm_hit ? ent_vsid[lm_idx] : '0;
   end

   // R1: nothing valid on the first edge after reset
   a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (valid_q == '0));
   // R3: errors only come from writes or reads
   a_r3_err_source: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(cmd_valid) && ($past(cmd_op) == OP_WRITE
                || $past(cmd_op) == OP_RD_ESID || $past(cmd_op) == OP_RD_VSID));
   // R8: a global flush only follows a global single invalidate
   a_r8_global_source: assert property (@(posedge clk) disable iff (!rst_n)
      flush_global |-> $past(cmd_valid) && ($past(cmd_op) == OP_INV_ONE_G));
   // R9: every invalidate-all raises a local flush
   a_r9_flush_always: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(cmd_valid && cmd_op == OP_INV_ALL) |-> flush_local);
   // R11: mode 7 in the new model leaves every valid bit alone
   a_r11_keep_all: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(cmd_valid && cmd_op == OP_INV_ALL && cfg_new_model
                            && cmd_mode == 3'd7) |-> valid_q == $past(valid_q));
endmodule

// File: tb/slb_array_bench.sv
module slb_array_bench;
   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  op;
      logic [63:0] addr;
      logic [63:0] data;
      logic        chk;
      logic        err;
      logic [63:0] exp;
   } vec_t;

   localparam logic [63:0] V0 = 64'h0000_0000_00AB_C000;
   localparam logic [63:0] V1 = 64'h4000_0000_00DE_F080;
   localparam logic [63:0] V2 = 64'h0000_0000_0055_5180;
   localparam logic [63:0] V5 = 64'h0000_0000_0077_7110;
   localparam logic [63:0] ONES = '1;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{4'd3, 3'd0, 64'h0000_0001_2800_0000, V0, 1'b0, 1'b0, 64'h0},   // R3 slot0
      '{4'd4, 3'd0, 64'h0000_0200_0800_0001, V1, 1'b0, 1'b0, 64'h0},   // R4 1TB ok
      '{4'd3, 3'd0, 64'h0000_0001_2800_0002, V2, 1'b0, 1'b0, 64'h0},   // R3 slot2
      '{4'd5, 3'd0, 64'h0000_0000_3800_0005, V5, 1'b0, 1'b0, 64'h0},   // R5 code 101
      '{4'd3, 3'd0, 64'h0000_0001_2800_0020, V0, 1'b0, 1'b1, 64'h0},   // R3 slot 32
      '{4'd3, 3'd0, 64'h0000_0001_2800_1003, V0, 1'b0, 1'b1, 64'h0},   // R3 reserved
      '{4'd4, 3'd0, 64'h0000_0001_2800_0003, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 64'h0}, // R4
      '{4'd5, 3'd0, 64'h0000_0001_2800_0003, 64'h0000_0000_0000_0010, 1'b0, 1'b1, 64'h0}, // R5
      '{4'd3, 3'd1, 64'h3, 64'h0, 1'b1, 1'b0, 64'h0},                  // R3 slot3 untouched
      '{4'd6, 3'd1, 64'h0, 64'h0, 1'b1, 1'b0, 64'h0000_0001_2800_0000}, // R6
      '{4'd6, 3'd2, 64'h1, 64'h0, 1'b1, 1'b0, V1},                     // R6
      '{4'd6, 3'd2, 64'h28, 64'h0, 1'b0, 1'b1, 64'h0},                 // R6 range
      '{4'd2, 3'd3, 64'h0000_0001_2345_6789, 64'h0, 1'b1, 1'b0, V0},   // R2 lowest wins
      '{4'd2, 3'd3, 64'h0000_0200_1234_5678, 64'h0, 1'b1, 1'b0, V1},   // R2 1TB
      '{4'd7, 3'd3, 64'h0000_0000_7000_0000, 64'h0, 1'b1, 1'b0, ONES}, // R7 miss
      '{4'd7, 3'd3, 64'hFFFF_FFFF_3000_1234, 64'h0, 1'b1, 1'b0, ONES}, // R7 64-bit
      '{4'd6, 3'd2, 64'h5, 64'h0, 1'b1, 1'b0, V5}                      // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_new_model = 1'b1, cfg_1t_en = 1'b1, cfg_mode32 = 1'b0;
   logic        lk_req = 1'b0;
   logic [35:0] lk_seg = '0;
   logic        lk_rsp_valid, lk_hit;
   logic [4:0]  lk_slot;
   logic [63:0] lk_vsid;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd7, cmd_mode = 3'd0;
   logic [63:0] cmd_addr = '0, cmd_data = '0;
   logic        rsp_valid, rsp_err, flush_local, flush_global;
   logic [63:0] rsp_data;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   slb_array u_slb_array (
      .clk(clk), .rst_n(rst_n), .cfg_new_model(cfg_new_model),
      .cfg_1t_en(cfg_1t_en), .cfg_mode32(cfg_mode32),
      .lk_req(lk_req), .lk_seg(lk_seg), .lk_rsp_valid(lk_rsp_valid),
      .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_vsid(lk_vsid),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .cmd_mode(cmd_mode), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_err(rsp_err), .flush_local(flush_local),
      .flush_global(flush_global));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] op, input logic [63:0] a,
                      input logic [63:0] d, input logic [2:0] m);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_mode = m;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd7;
   endtask

   task automatic lookup(input logic [35:0] s);
      @(negedge clk);
      lk_req = 1'b1; lk_seg = s;
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   task automatic populate();
      cmd(3'd0, 64'h0000_0001_2800_0000, V0, 3'd0);                    // class 0
      cmd(3'd0, 64'h0000_0004_0800_0001, 64'h0000_0000_0011_1080, 3'd0); // class 1
      cmd(3'd0, 64'h0000_0001_2800_0002, V2, 3'd0);                    // class 1
      cmd(3'd0, 64'h0000_0000_3800_0005, V5, 3'd0);                    // class 0
   endtask

   task automatic check_valid(input string req, input logic [3:0] exp);
      logic [3:0] got;
      cmd(3'd1, 64'd0, 64'd0, 3'd0); got[0] = rsp_data[27];
      cmd(3'd1, 64'd1, 64'd0, 3'd0); got[1] = rsp_data[27];
      cmd(3'd1, 64'd2, 64'd0, 3'd0); got[2] = rsp_data[27];
      cmd(3'd1, 64'd5, 64'd0, 3'd0); got[3] = rsp_data[27];
      check(req, 64'(got), 64'(exp));
   endtask

   task automatic inv_all(input string req, input logic [2:0] m);
      cmd(3'd6, 64'd0, 64'd0, m);
      check({req, " flush"}, 64'(flush_local), 64'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      check("R1 flush", 64'({flush_local, flush_global}), 64'd0);
      lookup(36'h12);
      check("R1 lookup miss", 64'(lk_hit), 64'd0);
      cmd(3'd1, 64'd0, 64'd0, 3'd0);
      check("R1 esid read", rsp_data, 64'd0);

      foreach (TBL[i]) begin
         cmd(TBL[i].op, TBL[i].addr, TBL[i].data, 3'd0);
         check($sformatf("R%0d vec%0d err", TBL[i].req, i), 64'(rsp_err), 64'(TBL[i].err));
         if (TBL[i].chk)
            check($sformatf("R%0d vec%0d data", TBL[i].req, i), rsp_data, TBL[i].exp);
      end

      // R12 registered lookup timing and R2 lookup port
      lookup(36'h12);
      check("R12 rsp_valid", 64'(lk_rsp_valid), 64'd1);
      check("R2 lookup slot", 64'({lk_hit, lk_slot}), 64'({1'b1, 5'd0}));
      check("R2 lookup vsid", lk_vsid, V0);
      @(negedge clk);
      check("R12 rsp_valid drops", 64'(lk_rsp_valid), 64'd0);
      lookup(36'h2001);
      check("R2 lookup 1TB", 64'({lk_hit, lk_slot}), 64'({1'b1, 5'd1}));
      lookup(36'h7);
      check("R12 miss vsid", 64'({lk_hit, lk_vsid}), 64'd0);

      // R7 32-bit search
      cfg_mode32 = 1'b1;
      cmd(3'd3, 64'hFFFF_FFFF_3000_1234, 64'd0, 3'd0);
      check("R7 mode32 search", rsp_data, V5);
      cfg_mode32 = 1'b0;

      // R4 1TB disabled
      cfg_1t_en = 1'b0;
      cmd(3'd0, 64'h0000_0300_0800_0006, 64'h4000_0000_0000_0000, 3'd0);
      check("R4 1TB disabled err", 64'(rsp_err), 64'd1);
      cmd(3'd1, 64'd6, 64'd0, 3'd0);
      check("R4 slot6 untouched", rsp_data, 64'd0);
      cfg_1t_en = 1'b1;

      // R8 single invalidate
      cmd(3'd4, 64'h0000_0001_2000_0000, 64'd0, 3'd0);
      check("R8 local flush", 64'({flush_local, flush_global}), 64'b10);
      lookup(36'h12);
      check("R8 next winner", 64'({lk_hit, lk_slot}), 64'({1'b1, 5'd2}));
      check("R2 next winner vsid", lk_vsid, V2);
      cmd(3'd5, 64'h0000_0000_7000_0000, 64'd0, 3'd0);
      check("R8 miss no flush", 64'({flush_local, flush_global}), 64'b00);
      cmd(3'd5, 64'h0000_0200_0000_0000, 64'd0, 3'd0);
      check("R8 global flush", 64'({flush_local, flush_global}), 64'b01);
      cmd(3'd1, 64'd1, 64'd0, 3'd0);
      check("R8 slot1 cleared", rsp_data, 64'h0000_0200_0000_0000);

      // invalidate-all modes; valid bits ordered {slot5, slot2, slot1, slot0}
      populate();
      inv_all("R11 mode7", 3'd7);
      check_valid("R11 mode7 keeps all", 4'b1111);
      inv_all("R10 mode3", 3'd3);
      check_valid("R10 mode3 keeps class0", 4'b1001);
      populate();
      inv_all("R10 mode4", 3'd4);
      check_valid("R10 mode4 clears all", 4'b0000);
      inv_all("R9 empty", 3'd0);
      populate();
      inv_all("R9 mode5", 3'd5);
      check_valid("R9 mode5 keeps slot0", 4'b0001);
      populate();
      inv_all("R9 mode6", 3'd6);
      check_valid("R9 mode6 keeps slot0", 4'b0001);
      cfg_new_model = 1'b0;
      populate();
      inv_all("R9 old mode3", 3'd3);
      check_valid("R9 old mode3", 4'b0001);
      populate();
      inv_all("R9 old mode7", 3'd7);
      check_valid("R9 old mode7", 4'b0001);
      cfg_new_model = 1'b1;

      // R1 reset mid-run
      populate();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check_valid("R1 reset clears", 4'b0000);
      lookup(36'h3);
      check("R1 lookup after reset", 64'(lk_hit), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule